// File: doc/BRIEF.md
# Multi-Dimensional Circular Transfer Engine

This block generates addresses and sequences word copies for a DMA engine. Sixteen channel descriptors are held on chip. Each descriptor gives a source base and a destination base, three nested counts, three signed strides for each side, a circular window length and a mode word. A pulse on a channel's trigger line queues that channel. Two execution slots each take a queued channel and move its words one at a time over a shared memory port. Each word is read from the source and then written to the destination.

Either side can wrap inside a circular window of any length. The wrap uses one compare and one add or subtract, not a power-of-two mask. In tap mode, one side is addressed at a list of offsets from a moving pointer inside the circular window. This supports multi-tap delay lines. When a channel's last word has been written, the engine raises a one-cycle done flag for that channel and frees the slot for the next queued channel.

Top module: `mdc_xfer_engine`

## Requirements
- R1: While reset is asserted, and after reset until a channel is triggered, `mem_req_o` and `done_o` stay low.
- R2: Count the clock edges since reset release. Slot 0 may drive the memory port only when an even number of edges has passed, and slot 1 only when an odd number has passed. Read data is taken from `mem_rdata_i` one cycle after the read request. The write that carries it is issued exactly two cycles after that read.
- R3: The innermost count steps first. When it is used up, it reloads and the next count steps. The offset of each side then adds the stride of the dimension that advanced. Offsets start at 0, the address is base plus offset (16-bit), and a count of 0 behaves as 1.
- R4: Mode bit 0 makes the source offset circular and mode bit 1 does the same for the destination. After each stride, an offset at or above the window length has the length subtracted, and a negative offset has the length added. Strides must be smaller in magnitude than the length.
- R5: Mode bit 2 selects tap mode. The taps go on the source side, or on the destination side when mode bit 3 is set. The count-0 value (at most 4) is the number of taps. The k-th element of a pass is addressed at base + ((p + tap k) mod length). The pointer p starts at 0 and advances by one, wrapping, after every full pass. Taps must be below the length, and the length must be below 32768.
- R6: Pending channels are started lowest number first. Slot 0 is filled before slot 1, and the two slots run at the same time.
- R7: A trigger for a channel that is running in a slot does not start it a second time. The trigger is held, and the channel runs again after it has finished.
- R8: The cycle after a channel's final write, `done_o` shows that channel's bit for exactly one cycle, and the slot can accept new work.
- R9: A descriptor write sets one field of the channel given by `desc_ch_i`. The field indices are: 0 source base, 1 destination base, 2 to 4 counts for dimensions 0 to 2, 5 to 7 source strides, 8 to 10 destination strides, 11 window length, 12 mode, and 13 to 16 taps 0 to 3. Indices above 16 leave the descriptor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Descriptor field write strobe |
| desc_ch_i | input | 4 | Channel selected for the write |
| desc_field_i | input | 5 | Field index |
| desc_data_i | input | 16 | Field value |
| trig_i | input | 16 | Per-channel trigger pulses |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after a read |
| done_o | output | 16 | One-cycle completion flag per channel |

## Verification
A trigger is registered at the edge where it is sampled, and the slot is loaded on the next edge. The first read can therefore appear two cycles after the trigger edge at the earliest, and then only in a cycle that belongs to that slot. The matching write follows two cycles after its read, and the done flag comes one cycle after the final write. Each slot's next read comes two cycles after its write. The bench samples every output at the falling edge. It uses its own edge count to decide which slot owns each request, and matches every request against that slot's queue of expected operations. Each done flag is checked in exactly the cycle after the final write that the bench itself saw.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int AW   = 16;
  localparam int CW   = 8;
  localparam int NTAP = 4;
  localparam int NCH  = 16;
  localparam int FW   = 5;

  typedef struct packed {
    logic [AW-1:0]            src_base;
    logic [AW-1:0]            dst_base;
    logic [2:0][CW-1:0]       cnt;
    logic [2:0][AW-1:0]       sstr;
    logic [2:0][AW-1:0]       dstr;
    logic [AW-1:0]            clen;
    logic [3:0]               mode;
    logic [NTAP-1:0][AW-1:0]  tap;
  } desc_t;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CAP, S_WR} slot_st_e;

  // offset + increment, folded once into [0,len) when circ is set
  function automatic logic [AW-1:0] circ_add(input logic [AW-1:0] off, input logic [AW-1:0] inc,
                                             input logic [AW-1:0] len, input logic circ);
    logic signed [AW+1:0] s;
    s = $signed({2'b00, off}) + $signed({{2{inc[AW-1]}}, inc});
    if (circ) begin
      if (s >= $signed({2'b00, len})) s = s - $signed({2'b00, len});
      else if (s < 0)                 s = s + $signed({2'b00, len});
    end
    return s[AW-1:0];
  endfunction
endpackage

// File: rtl/mdc_desc_store.sv
module mdc_desc_store
  import mdc_pkg::*;
#(
  parameter int NUM_CH = NCH,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CHW-1:0]  ch_i,
  input  logic [FW-1:0]   field_i,
  input  logic [AW-1:0]   data_i,
  output desc_t           desc_o [NUM_CH]
);
  desc_t desc_q [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CH; c++) desc_q[c] <= '0;
    end else if (we_i) begin
      if (field_i == 0) desc_q[ch_i].src_base <= data_i;
      if (field_i == 1) desc_q[ch_i].dst_base <= data_i;
      for (int k = 0; k < 3; k++) begin
        if (field_i == FW'(2 + k)) desc_q[ch_i].cnt[k]  <= data_i[CW-1:0];
        if (field_i == FW'(5 + k)) desc_q[ch_i].sstr[k] <= data_i;
        if (field_i == FW'(8 + k)) desc_q[ch_i].dstr[k] <= data_i;
      end
      if (field_i == 11) desc_q[ch_i].clen <= data_i;
      if (field_i == 12) desc_q[ch_i].mode <= data_i[3:0];
      for (int t = 0; t < NTAP; t++)
        if (field_i == FW'(13 + t)) desc_q[ch_i].tap[t] <= data_i;
    end
  end

  assign desc_o = desc_q;
endmodule

// File: rtl/mdc_arbiter.sv
module mdc_arbiter #(
  parameter int NUM_CH = 16,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CH-1:0]     trig_i,
  input  logic [NUM_CH-1:0]     active_i,
  input  logic [1:0]            free_i,
  output logic [1:0]            start_o,
  output logic [1:0][CHW-1:0]   start_ch_o
);
  logic [NUM_CH-1:0] pend_q, cand, first, rem, second, pick0, pick1;

  function automatic logic [CHW-1:0] enc(input logic [NUM_CH-1:0] oh);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++) if (oh[i]) r = CHW'(i);
    return r;
  endfunction

  always_comb begin
    cand   = pend_q & ~active_i;
    first  = cand & (~cand + 1'b1);
    rem    = cand & ~first;
    second = rem & (~rem + 1'b1);
    pick0  = free_i[0] ? first : '0;
    pick1  = free_i[1] ? (free_i[0] ? second : first) : '0;
  end

  assign start_o       = {|pick1, |pick0};
  assign start_ch_o[0] = enc(pick0);
  assign start_ch_o[1] = enc(pick1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~(pick0 | pick1)) | trig_i;
  end

  // R6: lowest channel goes to slot 0 when both take work
  a_r6_slot_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&start_o) |-> (start_ch_o[0] < start_ch_o[1]));
endmodule

// File: rtl/mdc_slot.sv
module mdc_slot
  import mdc_pkg::*;
#(
  parameter int NUM_CH = NCH,
  parameter int DW     = 16,
  localparam int CHW = $clog2(NUM_CH),
  localparam int TIW = $clog2(NTAP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            own_i,
  input  logic            start_i,
  input  logic [CHW-1:0]  start_ch_i,
  input  desc_t           desc_i,
  output logic            busy_o,
  output logic [CHW-1:0]  ch_o,
  output logic            done_o,
  output logic            req_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  input  logic [DW-1:0]   rdata_i
);
  slot_st_e        st_q;
  desc_t           d_q;
  logic [CHW-1:0]  ch_q;
  logic [CW-1:0]   i0_q, i1_q, i2_q;
  logic [TIW-1:0]  tix_q;
  logic [AW-1:0]   soff_q, doff_q, soff_n, doff_n, s_inc, d_inc;
  logic [DW-1:0]   data_q;
  logic            done_q, s_tap, d_tap, last;
  logic [1:0]      sel;
  logic [CW-1:0]   c0, c1;

  function automatic logic [CW-1:0] eff(input logic [CW-1:0] c);
    return (c == '0) ? CW'(1) : c;
  endfunction

  always_comb begin
    c0    = eff(d_q.cnt[0]);
    c1    = eff(d_q.cnt[1]);
    s_tap = d_q.mode[2] & ~d_q.mode[3];
    d_tap = d_q.mode[2] &  d_q.mode[3];
    last  = (i0_q == 1) && (i1_q == 1) && (i2_q == 1);
    sel   = (i0_q != 1) ? 2'd0 : (i1_q != 1) ? 2'd1 : 2'd2;
    s_inc = s_tap ? ((sel == 0) ? '0 : AW'(1)) : d_q.sstr[sel];
    d_inc = d_tap ? ((sel == 0) ? '0 : AW'(1)) : d_q.dstr[sel];
    soff_n = circ_add(soff_q, s_inc, d_q.clen, s_tap | d_q.mode[0]);
    doff_n = circ_add(doff_q, d_inc, d_q.clen, d_tap | d_q.mode[1]);
  end

  assign req_o   = own_i && (st_q == S_RD || st_q == S_WR);
  assign we_o    = (st_q == S_WR);
  assign addr_o  = (st_q == S_WR)
                 ? d_q.dst_base + (d_tap ? circ_add(doff_q, d_q.tap[tix_q], d_q.clen, 1'b1) : doff_q)
                 : d_q.src_base + (s_tap ? circ_add(soff_q, d_q.tap[tix_q], d_q.clen, 1'b1) : soff_q);
  assign wdata_o = data_q;
  assign busy_o  = (st_q != S_IDLE);
  assign ch_o    = ch_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; d_q <= '0; ch_q <= '0; done_q <= 1'b0; data_q <= '0;
      i0_q <= '0; i1_q <= '0; i2_q <= '0; tix_q <= '0; soff_q <= '0; doff_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          d_q <= desc_i; ch_q <= start_ch_i; st_q <= S_RD;
          i0_q <= eff(desc_i.cnt[0]); i1_q <= eff(desc_i.cnt[1]); i2_q <= eff(desc_i.cnt[2]);
          tix_q <= '0; soff_q <= '0; doff_q <= '0;
        end
        S_RD:   if (own_i) st_q <= S_CAP;
        S_CAP:  begin data_q <= rdata_i; st_q <= S_WR; end
        S_WR:   if (own_i) begin
          if (last) begin
            st_q <= S_IDLE; done_q <= 1'b1;
          end else begin
            st_q <= S_RD;
            soff_q <= soff_n; doff_q <= doff_n;
            if (sel == 0) begin
              i0_q <= i0_q - 1'b1; tix_q <= tix_q + 1'b1;
            end else begin
              i0_q <= c0; tix_q <= '0;
              if (sel == 1) i1_q <= i1_q - 1'b1;
              else begin i1_q <= c1; i2_q <= i2_q - 1'b1; end
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R2: each write comes two cycles after this slot's read
  a_r2_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> $past(req_o && !we_o, 2));
  // R4: a circular source offset stays inside its window
  a_r4_src_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && d_q.mode[0] && !d_q.mode[2] && d_q.clen != '0) |-> (soff_q < d_q.clen));
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/mdc_xfer_engine.sv
module mdc_xfer_engine
  import mdc_pkg::*;
#(
  parameter int NUM_CH = NCH,
  parameter int DW     = 16,
  localparam int CHW = $clog2(NUM_CH),
  localparam int NSLOT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_we_i,
  input  logic [CHW-1:0]    desc_ch_i,
  input  logic [FW-1:0]     desc_field_i,
  input  logic [AW-1:0]     desc_data_i,
  input  logic [NUM_CH-1:0] trig_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [NUM_CH-1:0] done_o
);
  desc_t desc [NUM_CH];
  logic phase_q;
  logic [NSLOT-1:0] start, busy, sdone, sreq, swe;
  logic [NSLOT-1:0][CHW-1:0] start_ch, sch;
  logic [NSLOT-1:0][AW-1:0] saddr;
  logic [NSLOT-1:0][DW-1:0] swdata;
  logic [NUM_CH-1:0] active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  mdc_desc_store #(.NUM_CH(NUM_CH)) i_store (
    .clk_i, .rst_ni, .we_i(desc_we_i), .ch_i(desc_ch_i),
    .field_i(desc_field_i), .data_i(desc_data_i), .desc_o(desc));

  mdc_arbiter #(.NUM_CH(NUM_CH)) i_arb (
    .clk_i, .rst_ni, .trig_i, .active_i(active), .free_i(~busy),
    .start_o(start), .start_ch_o(start_ch));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    mdc_slot #(.NUM_CH(NUM_CH), .DW(DW)) i_slot (
      .clk_i, .rst_ni, .own_i(phase_q == s[0]), .start_i(start[s]),
      .start_ch_i(start_ch[s]), .desc_i(desc[start_ch[s]]),
      .busy_o(busy[s]), .ch_o(sch[s]), .done_o(sdone[s]),
      .req_o(sreq[s]), .we_o(swe[s]), .addr_o(saddr[s]),
      .wdata_o(swdata[s]), .rdata_i(mem_rdata_i));
  end

  always_comb begin
    active = '0;
    done_o = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (busy[s])  active[sch[s]] = 1'b1;
      if (sdone[s]) done_o[sch[s]] = 1'b1;
    end
  end

  assign mem_req_o   = |sreq;
  assign mem_we_o    = sreq[1] ? swe[1]    : swe[0];
  assign mem_addr_o  = sreq[1] ? saddr[1]  : saddr[0];
  assign mem_wdata_o = sreq[1] ? swdata[1] : swdata[0];

  // R2: never two slots on the port in one cycle
  a_r2_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sreq));
  // R7: one channel never occupies both slots
  a_r7_no_double_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&busy) |-> (sch[0] != sch[1]));
  // R8: completions never coincide
  a_r8_done_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

// File: tb/test_mdc_xfer_engine.sv
module test_mdc_xfer_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_we = 1'b0;
  logic [3:0] desc_ch = '0;
  logic [4:0] desc_field = '0;
  logic [15:0] desc_data = '0, trig = '0;
  logic mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, done;
  logic [15:0] mem [256];

  always #5 clk = ~clk;

  mdc_xfer_engine i_mdc_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n), .desc_we_i(desc_we), .desc_ch_i(desc_ch),
    .desc_field_i(desc_field), .desc_data_i(desc_data), .trig_i(trig),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done));

  function automatic logic [15:0] init_val(input int a);
    return 16'((a * 37 + 5) & 16'hffff);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_req && mem_we)  mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  string cur_tag = "R3";
  int b_src[16], b_dst[16], b_len[16], b_mode[16];
  int b_cnt[16][3], b_ss[16][3], b_ds[16][3], b_tap[16][4];
  int q_ra[2][$], q_wa[2][$];
  int q_ch[2], rd_cyc[2];
  bit s_busy[2], wr_next[2];
  logic [15:0] wait_mask = '0, exp_done = '0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int adv(input int v, input int st, input int circ, input int len);
    int r;
    r = v + st;
    if (circ != 0) begin
      if (r >= len) r -= len;
      else if (r < 0) r += len;
    end
    return r;
  endfunction

  // expected read/write address lists for one run of channel ch in slot s
  task automatic build(input int ch, input int s);
    int c0, c1, c2, so, dof, p, sel, ra, wa, len;
    bit tp, td;
    c0 = b_cnt[ch][0]; c1 = b_cnt[ch][1]; c2 = b_cnt[ch][2];
    len = b_len[ch]; tp = b_mode[ch][2]; td = b_mode[ch][3];
    so = 0; dof = 0;
    for (int k2 = 0; k2 < c2; k2++)
      for (int k1 = 0; k1 < c1; k1++)
        for (int k0 = 0; k0 < c0; k0++) begin
          p  = tp ? (k2 * c1 + k1) % len : 0;
          ra = (tp && !td) ? b_src[ch] + (p + b_tap[ch][k0]) % len : b_src[ch] + so;
          wa = (tp && td)  ? b_dst[ch] + (p + b_tap[ch][k0]) % len : b_dst[ch] + dof;
          q_ra[s].push_back(ra & 16'hffff);
          q_wa[s].push_back(wa & 16'hffff);
          sel = (k0 < c0 - 1) ? 0 : (k1 < c1 - 1) ? 1 : 2;
          so  = adv(so,  b_ss[ch][sel], b_mode[ch][0], len);
          dof = adv(dof, b_ds[ch][sel], b_mode[ch][1], len);
        end
    q_ch[s] = ch; s_busy[s] = 1; wr_next[s] = 0;
  endtask

  task automatic pick_next(input int s);
    int o;
    o = 1 - s;
    for (int c = 0; c < 16; c++)
      if (wait_mask[c] && !(s_busy[o] && q_ch[o] == c)) begin
        wait_mask[c] = 1'b0;
        build(c, s);
        break;
      end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int s;
    if (rst_n && !finished) begin
      s = cyc % 2;
      chk(done == exp_done, "R8 done flag", done, exp_done);
      exp_done = '0;
      if (mem_req) begin
        if (q_ra[s].size() == 0) chk(0, "R2 request with no work for slot", mem_addr, 0);
        else if (!wr_next[s]) begin
          chk(!mem_we, "R2 read expected", mem_we, 0);
          chk(mem_addr == 16'(q_ra[s][0]), {cur_tag, " read address"}, mem_addr, q_ra[s][0]);
          rd_cyc[s] = cyc; wr_next[s] = 1;
        end else begin
          chk(mem_we, "R2 write expected", mem_we, 1);
          chk(cyc == rd_cyc[s] + 2, "R2 write two cycles after read", cyc, rd_cyc[s] + 2);
          chk(mem_addr == 16'(q_wa[s][0]), {cur_tag, " write address"}, mem_addr, q_wa[s][0]);
          chk(mem_wdata == init_val(q_ra[s][0] & 255), "R2 write data", mem_wdata, init_val(q_ra[s][0] & 255));
          void'(q_ra[s].pop_front()); void'(q_wa[s].pop_front());
          wr_next[s] = 0;
          if (q_ra[s].size() == 0) begin
            exp_done = 16'(1) << q_ch[s];
            s_busy[s] = 0;
            pick_next(s);
          end
        end
      end
    end
  end

  task automatic wr_field(input int ch, input int f, input int v);
    @(negedge clk);
    desc_we = 1'b1; desc_ch = 4'(ch); desc_field = 5'(f); desc_data = 16'(v);
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  // R9 field map: 0 src, 1 dst, 2-4 counts, 5-7 src strides, 8-10 dst strides, 11 length, 12 mode, 13-16 taps
  task automatic prog(input int ch, input int src, input int dst, input int c0, input int c1, input int c2,
                      input int s0, input int s1, input int s2, input int d0, input int d1, input int d2,
                      input int len, input int mode, input int t0, input int t1, input int t2, input int t3);
    int v[17];
    v = '{src, dst, c0, c1, c2, s0, s1, s2, d0, d1, d2, len, mode, t0, t1, t2, t3};
    for (int f = 0; f < 17; f++) wr_field(ch, f, v[f]);
    b_src[ch] = src; b_dst[ch] = dst; b_len[ch] = len; b_mode[ch] = mode;
    b_cnt[ch] = '{c0, c1, c2}; b_ss[ch] = '{s0, s1, s2}; b_ds[ch] = '{d0, d1, d2};
    b_tap[ch] = '{t0, t1, t2, t3};
  endtask

  task automatic fire(input logic [15:0] m);
    @(negedge clk);
    trig = m;
    #1;
    for (int c = 0; c < 16; c++)
      if (m[c]) begin
        if ((s_busy[0] && q_ch[0] == c) || (s_busy[1] && q_ch[1] == c) || wait_mask[c])
          wait_mask[c] = 1'b1;
        else if (!s_busy[0]) build(c, 0);
        else if (!s_busy[1]) build(c, 1);
        else wait_mask[c] = 1'b1;
      end
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_idle(input string tag);
    int t;
    t = 0;
    while ((s_busy[0] || s_busy[1] || wait_mask != 0) && t < 3000) begin
      @(negedge clk); #1; t++;
    end
    chk(t < 3000, {tag, " transfer finished"}, t, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req && done == 0, "R1 outputs low in reset", {mem_req, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && done == 0, "R1 outputs low after reset", {mem_req, done}, 0);

    // R3 one-dimensional copy
    cur_tag = "R3";
    prog(3, 10, 128, 5, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    fire(16'h0008); wait_idle("R3 1D");
    // R3 two-dimensional with negative strides
    prog(1, 40, 150, 3, 2, 1, 2, -7, 0, -1, 8, 0, 0, 0, 0, 0, 0, 0);
    fire(16'h0002); wait_idle("R3 2D");
    // R3 three-dimensional
    prog(0, 12, 160, 2, 2, 2, 1, 3, 10, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    fire(16'h0001); wait_idle("R3 3D");
    // R4 circular source, length 5, stride 2
    cur_tag = "R4";
    prog(7, 60, 168, 7, 1, 1, 2, 0, 0, 1, 0, 0, 5, 1, 0, 0, 0, 0);
    fire(16'h0080); wait_idle("R4 src circ");
    // R4 circular destination, length 6, negative inner stride
    prog(8, 70, 176, 4, 2, 1, 1, 1, 0, -2, 3, 0, 6, 2, 0, 0, 0, 0);
    fire(16'h0100); wait_idle("R4 dst circ");
    // R5 taps on source
    cur_tag = "R5";
    prog(12, 80, 184, 3, 4, 1, 0, 0, 0, 1, 1, 0, 7, 4, 0, 3, 6, 1);
    fire(16'h1000); wait_idle("R5 src taps");
    // R5 taps on destination, three-dimensional pass count
    prog(13, 90, 200, 4, 3, 2, 1, 1, 1, 0, 0, 0, 9, 12, 2, 8, 5, 0);
    fire(16'h2000); wait_idle("R5 dst taps");
    // R6 three channels at once: 2 and 5 run together, 9 follows
    cur_tag = "R6";
    prog(2, 0, 210, 4, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    prog(5, 20, 220, 6, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    prog(9, 30, 230, 3, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    fire(16'h0224); wait_idle("R6 concurrent");
    // R7 retrigger while running is held and replayed
    cur_tag = "R7";
    fire(16'h0020);
    repeat (6) @(negedge clk);
    fire(16'h0020); wait_idle("R7 retrigger");
    // R9 out-of-range field index leaves channel 3 untouched
    cur_tag = "R9";
    wr_field(3, 20, 16'hffff);
    wr_field(3, 31, 16'h1234);
    fire(16'h0008); wait_idle("R9 ignored field");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 0, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule